// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the four interrupt sources of a serial port into one active-high interrupt request and a readable identification byte. The four sources are receiver line status, received data (trigger level reached, or a receive timeout), transmit holding empty, and modem status. An 8-bit enable register gates each source. When software reads the identification byte, it gets the highest-priority enabled source that is pending. While the FIFOs are on, the top two bits of that byte are set.

The block does not detect the source conditions itself. The received-data condition arrives as a level that compares the FIFO count against the trigger. Line status, timeout, transmit empty and modem status arrive as single-cycle events, and the block holds each one in its own pending latch. The register decoder outside the block supplies write and read strobes. The identification read strobe may last several clocks, and its value is frozen for the whole access.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01, the enable readback is 0x00 and `irq_o` is low.
- R2: Codes in `iir_o[3:0]`, highest priority first: 0110 line status, then 0100 data ready and 1100 receive timeout (both at level two, with data ready ahead of timeout), then 0010 transmit empty, then 0000 modem status. 0001 means nothing is pending.
- R3: `irq_o` is high exactly when `iir_o[0]` is 0.
- R4: Enable bit 0 gates data ready and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem status. Bits 7:4 of `ier_o` always read 0.
- R5: `iir_o[7:6]` is 11 when `fifo_en_i` is high and 00 otherwise. `iir_o[5:4]` is always 00.
- R6: An identification read that reports transmit empty clears that latch. A read that reports any other code changes no source. The next lower pending source then becomes visible.
- R7: The data-ready source follows `rx_at_trig_i` in the same cycle and has no latch.
- R8: The transmit-empty latch sets on `tx_empty_evt_i` and clears on `thr_wr_i`.
- R9: The line-status latch clears on `lsr_rd_i`, the modem latch on `msr_rd_i` and the timeout latch on `rhr_rd_i`. For every latch, a set event wins over a clear in the same cycle.
- R10: The identification byte is captured in the first cycle of `iir_rd_i` and holds that value until the strobe drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Write strobe for the enable register |
| ier_wdata_i | input | 8 | Enable write data |
| ier_o | output | 8 | Enable readback |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_at_trig_i | input | 1 | Receive FIFO count at or above trigger |
| rx_tmo_evt_i | input | 1 | Receive timeout event |
| line_evt_i | input | 1 | Line status error event |
| modem_evt_i | input | 1 | Modem status change event |
| tx_empty_evt_i | input | 1 | Transmit holding empty event |
| thr_wr_i | input | 1 | Transmit holding / FIFO write strobe |
| rhr_rd_i | input | 1 | Receive data read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| iir_rd_i | input | 1 | Identification read strobe (may span cycles) |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every event input is low while reset is asserted. They also assume that the identification strobe, once raised, stays high for whole cycles and does not glitch. The stimulus drives every input only at falling edges and holds all inputs at zero through reset. It mixes directed sequences of overlapping sources and multi-cycle read strobes with pseudo-random traffic. Each cycle it compares the outputs against a behavioural model of the latches and the priority order.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CODE_W-1:0] CODE_NONE  = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_RXRDY = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TMO   = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_TX    = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 4'b0000;

  typedef struct packed {
    logic line;
    logic rxrdy;
    logic tmo;
    logic tx;
    logic modem;
  } irq_src_t;
endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;   // set wins over clear
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_src_t            src_i,
  output logic [CODE_W-1:0]   code_o
);
  always_comb begin
    if (src_i.line)       code_o = CODE_LINE;
    else if (src_i.rxrdy) code_o = CODE_RXRDY;
    else if (src_i.tmo)   code_o = CODE_TMO;
    else if (src_i.tx)    code_o = CODE_TX;
    else if (src_i.modem) code_o = CODE_MODEM;
    else                  code_o = CODE_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ier_wr_i,
  input  logic [BYTE_W-1:0] ier_wdata_i,
  output logic [BYTE_W-1:0] ier_o,
  input  logic              fifo_en_i,
  input  logic              rx_at_trig_i,
  input  logic              rx_tmo_evt_i,
  input  logic              line_evt_i,
  input  logic              modem_evt_i,
  input  logic              tx_empty_evt_i,
  input  logic              thr_wr_i,
  input  logic              rhr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              msr_rd_i,
  input  logic              iir_rd_i,
  output logic [BYTE_W-1:0] iir_o,
  output logic              irq_o
);
  localparam int unsigned N_EN = 4;
  localparam int unsigned N_LATCH = 4;

  logic [N_EN-1:0]   en_q;
  logic              rd_q;
  logic [BYTE_W-1:0] hold_q;
  logic [CODE_W-1:0] code;
  logic [BYTE_W-1:0] live;
  logic              rd_rise;
  logic [N_LATCH-1:0] set_v, clr_v, pend_v;
  irq_src_t          gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (ier_wr_i) en_q <= ier_wdata_i[N_EN-1:0];
  end
  assign ier_o = {{(BYTE_W-N_EN){1'b0}}, en_q};

  assign rd_rise = iir_rd_i && !rd_q;

  // latch order: 0 line, 1 timeout, 2 tx, 3 modem
  assign set_v = {modem_evt_i, tx_empty_evt_i, rx_tmo_evt_i, line_evt_i};
  assign clr_v = {msr_rd_i,
                  thr_wr_i | (rd_rise && code == CODE_TX),
                  rhr_rd_i,
                  lsr_rd_i};

  for (genvar g = 0; g < N_LATCH; g++) begin : g_src
    uart_irq_latch u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  always_comb begin
    gated.line  = pend_v[0] & en_q[2];
    gated.rxrdy = rx_at_trig_i & en_q[0];
    gated.tmo   = pend_v[1] & en_q[0];
    gated.tx    = pend_v[2] & en_q[1];
    gated.modem = pend_v[3] & en_q[3];
  end

  uart_irq_prio u_prio (
    .src_i  (gated),
    .code_o (code)
  );

  assign live = {{2{fifo_en_i}}, 2'b00, code};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      hold_q <= {4'b0000, CODE_NONE};
    end else begin
      rd_q <= iir_rd_i;
      if (rd_rise) hold_q <= live;
    end
  end

  assign iir_o = rd_q ? hold_q : live;
  assign irq_o = |gated;

  a_r3_irq_vs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |-> (irq_o == !iir_o[0]));
  a_r10_hold_during_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && rd_q) |=> (iir_rd_i -> $stable(iir_o)));
  a_r6_tx_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && iir_o[3:0] == CODE_TX && !tx_empty_evt_i) |=> !pend_v[2]);
  a_r9_line_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !line_evt_i) |=> !pend_v[0]);
  a_r2_line_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v[0] && en_q[2] && !rd_q) |-> iir_o[3:0] == CODE_LINE);
  a_r5_upper_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |-> (iir_o[7:6] == {2{fifo_en_i}} && iir_o[5:4] == 2'b00));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, fifo_en = 0, rx_trig = 0, tmo_evt = 0, line_evt = 0, modem_evt = 0;
  logic tx_evt = 0, thr_wr = 0, rhr_rd = 0, lsr_rd = 0, msr_rd = 0, iir_rd = 0;
  logic [7:0] ier_wd = 0;
  logic [7:0] ier_o, iir_o;
  logic irq_o;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_irq_ident dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wd), .ier_o(ier_o),
    .fifo_en_i(fifo_en), .rx_at_trig_i(rx_trig), .rx_tmo_evt_i(tmo_evt),
    .line_evt_i(line_evt), .modem_evt_i(modem_evt), .tx_empty_evt_i(tx_evt),
    .thr_wr_i(thr_wr), .rhr_rd_i(rhr_rd), .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd),
    .iir_rd_i(iir_rd), .iir_o(iir_o), .irq_o(irq_o));

  // behavioural reference
  bit m_line, m_tmo, m_tx, m_modem, m_rd;
  bit [7:0] m_en, m_hold;

  function automatic bit [3:0] m_code();
    if (m_line && m_en[2]) return 4'h6;
    if (rx_trig && m_en[0]) return 4'h4;
    if (m_tmo && m_en[0]) return 4'hC;
    if (m_tx && m_en[1]) return 4'h2;
    if (m_modem && m_en[3]) return 4'h0;
    return 4'h1;
  endfunction

  function automatic bit [7:0] m_live();
    return {fifo_en ? 2'b11 : 2'b00, 2'b00, m_code()};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_tmo = 0; m_tx = 0; m_modem = 0; m_rd = 0; m_en = 0; m_hold = 8'h01;
    end else begin
      bit rise;
      bit [7:0] lv;
      rise = iir_rd && !m_rd;
      lv = m_live();
      if (rise) m_hold = lv;
      m_line  = line_evt  ? 1'b1 : (lsr_rd ? 1'b0 : m_line);
      m_tmo   = tmo_evt   ? 1'b1 : (rhr_rd ? 1'b0 : m_tmo);
      m_modem = modem_evt ? 1'b1 : (msr_rd ? 1'b0 : m_modem);
      m_tx    = tx_evt    ? 1'b1 : ((thr_wr || (rise && lv[3:0] == 4'h2)) ? 1'b0 : m_tx);
      if (ier_wr) m_en = {4'h0, ier_wd[3:0]};
      m_rd = iir_rd;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare every cycle after inputs settle
  always @(negedge clk) if (rst_n) begin
    #2;
    chk("R2 iir", iir_o, m_rd ? m_hold : m_live());
    chk("R3 irq", irq_o, (m_rd ? 1'b1 : (m_code() != 4'h1)) ? ((m_code() != 4'h1) ? 1 : 0) : 0);
    chk("R4 ier", ier_o, m_en);
  end

  task automatic clr_in();
    ier_wr = 0; tmo_evt = 0; line_evt = 0; modem_evt = 0; tx_evt = 0;
    thr_wr = 0; rhr_rd = 0; lsr_rd = 0; msr_rd = 0;
  endtask

  task automatic cyc(); @(negedge clk); clr_in(); endtask
  task automatic look(); @(negedge clk); clr_in(); #3; endtask

  initial begin
    #5000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    chk("R1 reset iir", iir_o, 8'h01);
    chk("R1 reset ier", ier_o, 8'h00);
    chk("R1 reset irq", irq_o, 0);
    // R4: upper enable bits dropped, gating per source
    @(negedge clk); ier_wr = 1; ier_wd = 8'hF2; look();
    chk("R4 ier upper", ier_o, 8'h02);
    @(negedge clk); line_evt = 1; modem_evt = 1; tmo_evt = 1; look();
    chk("R4 gated off", iir_o, 8'h01);
    @(negedge clk); ier_wr = 1; ier_wd = 8'h0F; look();
    chk("R2 line first", iir_o[3:0], 4'h6);
    @(negedge clk); fifo_en = 1; #3;
    chk("R5 fifo bits", iir_o, 8'hC6);
    // R6: ident read on line status leaves it set
    @(negedge clk); iir_rd = 1; look(); look(); iir_rd = 0; look();
    chk("R6 no clear", iir_o[3:0], 4'h6);
    @(negedge clk); lsr_rd = 1; look();
    chk("R9 lsr clear", iir_o[3:0], 4'hC);
    @(negedge clk); rx_trig = 1; #3;
    chk("R7 rx level", iir_o[3:0], 4'h4);
    @(negedge clk); rx_trig = 0; #3;
    chk("R7 rx drop", iir_o[3:0], 4'hC);
    @(negedge clk); rhr_rd = 1; tx_evt = 1; look();
    chk("R8 tx set", iir_o[3:0], 4'h2);
    // R10: hold while strobe high, even if a higher source arrives
    @(negedge clk); iir_rd = 1; #3;
    chk("R10 first", iir_o[3:0], 4'h2);
    @(negedge clk); line_evt = 1; look(); look();
    chk("R10 held", iir_o[3:0], 4'h2);
    @(negedge clk); iir_rd = 0; lsr_rd = 1; look();
    chk("R6 tx cleared", iir_o[3:0], 4'h0);
    @(negedge clk); msr_rd = 1; modem_evt = 1; look();
    chk("R9 set wins", iir_o[3:0], 4'h0);
    @(negedge clk); msr_rd = 1; look();
    chk("R9 msr clear", iir_o, 8'hC1);
    chk("R3 idle irq", irq_o, 0);
    @(negedge clk); tx_evt = 1; look();
    @(negedge clk); thr_wr = 1; look();
    chk("R8 thr clear", iir_o[3:0], 4'h1);
    // random traffic, checked by the per-cycle model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      clr_in();
      {ier_wr, tmo_evt, line_evt, modem_evt, tx_evt} = $urandom & $urandom & 5'h1F;
      {thr_wr, rhr_rd, lsr_rd, msr_rd} = $urandom & $urandom & 4'hF;
      ier_wd = $urandom;
      if (($urandom % 4) == 0) rx_trig = ~rx_trig;
      if (($urandom % 5) == 0) iir_rd = ~iir_rd;
      if (($urandom % 50) == 0) fifo_en = ~fifo_en;
    end
    cyc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule